// File: doc/BRIEF.md
# Halt-Detect Clock Stop Controller

This block decides when a processor's system clocks are to be halted and when they run again. It watches three processor status inputs and a start input, all sampled on the rising edge of the system clock. A halt is accepted only as a two-step sequence: the passive code must appear in one sampled cycle and the halt code in the very next. A single stray halt code, such as one seen while the bus lines settle mid-cycle, does nothing.

Once a halt is accepted, the controller commits to stopping and keeps the system clock enable high for a fixed number of further cycles. It then drops the enable so that downstream gating parks the main and 50% clocks high. A source-select input, captured when the stop is committed, chooses what else stops. With the crystal selected, the oscillator-run request falls along with the enable. With an external source selected, the oscillator request stays high and only the clock enable is withdrawn. A peripheral clock divider inside the block stops toggling and holds its current level while the enable is low.

A start pulse cancels a pending or completed stop. The sequence must then be armed again from scratch. When the two low status lines are tied high, the top status line can be used on its own as a falling-edge stop line. All pins are plain control and status levels, with no data stream and no handshake.

Top module: `hcs_halt_clk_ctrl`

## Requirements
- R1: `stat_i` is read as {line2, line1, line0} and sampled on each rising edge. The passive code is 3'b111 and the halt code is 3'b011. A halt is accepted only when a sample of 3'b111 is followed directly by a sample of 3'b011.
- R2: A 3'b011 sample whose previous sample was not 3'b111 is ignored and `clk_en_o` stays high. Examples are 3'b011 following 3'b101 or 3'b001.
- R3: Let edge E be the edge that first samples 3'b011 directly after a 3'b111 sample. `stopping_o` rises after edge E+1, and `clk_en_o` falls after edge E+1+STOP_LAG (STOP_LAG = 2 by default).
- R4: `src_ext_i` is captured at edge E+1. If it was low (crystal), `osc_run_o` falls together with `clk_en_o`. If it was high (external source), `osc_run_o` stays high throughout the stop.
- R5: If `start_i` is sampled high at edge A, then after edge A+1 `clk_en_o` and `osc_run_o` are high and `stopping_o` is low. This holds whether the stop was pending or complete, and whatever level `stat_i` has.
- R6: After reset or a start, a held or repeated 3'b011 does not stop the clocks until a new 3'b111 sample precedes it. A passive-then-halt pair is also ignored if `start_i` is sampled high on either of its two edges.
- R7: `pclk_o` toggles every PCLK_HALF edges (default 1) at which the clock enable was high before the edge. While the enable is low, `pclk_o` holds its level.
- R8: With line1 and line0 held high, a line2 that is high for at least one sampled cycle and then falls produces an accepted halt.
- R9: During and directly after reset, `clk_en_o` = 1, `osc_run_o` = 1, `stopping_o` = 0 and `pclk_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_i | input | 3 | Processor status lines {line2, line1, line0}; line2 doubles as stop line |
| start_i | input | 1 | Start command, active high |
| src_ext_i | input | 1 | Source select: 0 crystal oscillator, 1 external frequency source |
| clk_en_o | output | 1 | System clock enable; low means main and 50% clocks parked high |
| osc_run_o | output | 1 | Oscillator run request |
| stopping_o | output | 1 | Stop committed (draining or halted) |
| pclk_o | output | 1 | Peripheral clock, frozen while stopped |

## Verification
The hardest situation to reach is a start that lands inside the drain window, after the stop has been committed but before the enable has fallen. A second hard case is a start that coincides with the edge sampling the halt code. In both cases the stop must vanish without a single low cycle on the enable. Directed stimulus places the start pulse exactly one edge after the halt sample, and again on the same edge as it. A long pseudo-random phase then mixes status codes, start pulses and source changes, so that the behavioural model meets both timings many more times.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] ST_PASSIVE = 3'b111;
  localparam logic [STAT_W-1:0] ST_HALT    = 3'b011;

  typedef enum logic [1:0] {
    SEQ_RUN   = 2'd0,
    SEQ_DRAIN = 2'd1,
    SEQ_HALT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/hcs_status_qual.sv
module hcs_status_qual
  import hcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              start_i,
  output logic              start_s,
  output logic              decode
);
  logic [STAT_W-1:0] st_q;
  logic              start_q;
  logic              arm_q;

  // The reset value is not the passive code, so a halt code sampled right after reset cannot match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      start_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      st_q    <= stat_i;
      start_q <= start_i;
      arm_q   <= (st_q == ST_PASSIVE) && !start_q;
    end
  end

  assign start_s = start_q;
  assign decode  = arm_q && (st_q == ST_HALT) && !start_q;

  // R1
  passive_before_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decode |-> ($past(st_q) == ST_PASSIVE));

  // R6
  rearm_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !decode);
endmodule

// File: rtl/hcs_stop_seq.sv
module hcs_stop_seq
  import hcs_pkg::*;
#(
  parameter int STOP_LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_s,
  input  logic decode,
  input  logic src_ext_i,
  output logic run,
  output logic stopping,
  output logic osc_run
);
  localparam int CW = (STOP_LAG < 2) ? 1 : $clog2(STOP_LAG + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(STOP_LAG - 1);

  seq_state_t      state_q;
  logic [CW-1:0]   cnt_q;
  logic            osc_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_RUN;
      cnt_q     <= '0;
      osc_off_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_RUN: begin
          if (decode && !start_s) begin
            state_q   <= SEQ_DRAIN;
            cnt_q     <= CNT_LOAD;
            osc_off_q <= !src_ext_i;
          end
        end
        SEQ_DRAIN: begin
          if (start_s) begin
            state_q   <= SEQ_RUN;
            osc_off_q <= 1'b0;
          end else if (cnt_q == '0) begin
            state_q <= SEQ_HALT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_HALT: begin
          if (start_s) begin
            state_q   <= SEQ_RUN;
            osc_off_q <= 1'b0;
          end
        end
        default: state_q <= SEQ_RUN;
      endcase
    end
  end

  assign run      = (state_q != SEQ_HALT);
  assign stopping = (state_q != SEQ_RUN);
  assign osc_run  = !((state_q == SEQ_HALT) && osc_off_q);

  // R3
  commit_follows_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopping) |-> $past(decode));

  // R3
  enable_falls_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(stopping));

  // R5
  start_resumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_s |=> (run && !stopping && osc_run));

  // R4
  osc_only_when_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> !run);
endmodule

// File: rtl/hcs_pclk_div.sv
module hcs_pclk_div #(
  parameter int PCLK_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pclk
);
  logic pclk_q;

  generate
    if (PCLK_HALF <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pclk_q <= 1'b0;
        else if (run) pclk_q <= ~pclk_q;
      end
    end else begin : g_count
      localparam int DW = $clog2(PCLK_HALF);
      localparam logic [DW-1:0] LAST = DW'(PCLK_HALF - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          div_q  <= '0;
          pclk_q <= 1'b0;
        end else if (run) begin
          if (div_q == LAST) begin
            div_q  <= '0;
            pclk_q <= ~pclk_q;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      end
    end
  endgenerate

  assign pclk = pclk_q;

  // R7
  pclk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pclk_q));
endmodule

// File: rtl/hcs_halt_clk_ctrl.sv
module hcs_halt_clk_ctrl
  import hcs_pkg::*;
#(
  parameter int STOP_LAG  = 2,
  parameter int PCLK_HALF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              start_i,
  input  logic              src_ext_i,
  output logic              clk_en_o,
  output logic              osc_run_o,
  output logic              stopping_o,
  output logic              pclk_o
);
  logic start_s;
  logic decode;
  logic run;

  hcs_status_qual u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_i  (stat_i),
    .start_i (start_i),
    .start_s (start_s),
    .decode  (decode)
  );

  hcs_stop_seq #(.STOP_LAG(STOP_LAG)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_s   (start_s),
    .decode    (decode),
    .src_ext_i (src_ext_i),
    .run       (run),
    .stopping  (stopping_o),
    .osc_run   (osc_run_o)
  );

  hcs_pclk_div #(.PCLK_HALF(PCLK_HALF)) u_pclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .pclk  (pclk_o)
  );

  assign clk_en_o = run;
endmodule

// File: tb/tb_hcs_halt_clk_ctrl.sv
module tb_hcs_halt_clk_ctrl;
  localparam int STOP_LAG = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stat = 3'b000;
  logic       start = 1'b0;
  logic       src_ext = 1'b0;
  logic       clk_en, osc_run, stopping, pclk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  hcs_halt_clk_ctrl #(.STOP_LAG(STOP_LAG), .PCLK_HALF(1)) dut (
    .clk(clk), .rst_n(rst_n), .stat_i(stat), .start_i(start), .src_ext_i(src_ext),
    .clk_en_o(clk_en), .osc_run_o(osc_run), .stopping_o(stopping), .pclk_o(pclk)
  );

  always #10 clk = ~clk;

  // Behavioural reference: sample history and event times, updated at each rising edge.
  logic [2:0] m_prev;
  bit m_sprev, m_dec, m_stopping, m_run, m_osc, m_ext, m_pclk;
  int cyc, m_stop_at;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 3'b000; m_sprev = 0; m_dec = 0; m_stopping = 0; m_run = 1;
      m_osc = 1; m_ext = 0; m_pclk = 0; cyc = 0; m_stop_at = 0;
    end else begin
      cyc++;
      if (m_run) m_pclk = ~m_pclk;
      if (m_sprev) begin
        m_stopping = 0; m_run = 1; m_osc = 1;
      end else if (m_dec && !m_stopping) begin
        m_stopping = 1; m_ext = src_ext; m_stop_at = cyc + STOP_LAG;
      end else if (m_stopping && m_run && cyc == m_stop_at) begin
        m_run = 0; m_osc = m_ext;
      end
      m_dec  = (stat == 3'b011) && (m_prev == 3'b111) && !m_sprev && !start;
      m_prev = stat;
      m_sprev = start;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at t=%0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 clk_en", clk_en, m_run);
      chk("R3 stopping", stopping, m_stopping);
      chk("R4 osc_run", osc_run, m_osc);
      chk("R7 pclk", pclk, m_pclk);
    end
  end

  task automatic step(input logic [2:0] s, input logic st, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stat = s;
      start = st;
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic p;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 clk_en", clk_en, 1'b1);
    chk("R9 osc_run", osc_run, 1'b1);
    chk("R9 stopping", stopping, 1'b0);
    chk("R9 pclk", pclk, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R4: passive then halt, crystal selected
    src_ext = 1'b0;
    step(3'b111, 0, 3);
    step(3'b011, 0, 6);
    chk("R1 clk_en", clk_en, 1'b0);
    chk("R4 osc_run crystal", osc_run, 1'b0);
    p = pclk;
    step(3'b011, 0, 4);
    chk("R7 pclk frozen", pclk, p);

    // R5 start with stop line still low
    step(3'b011, 1, 1);
    step(3'b011, 0, 3);
    chk("R5 clk_en", clk_en, 1'b1);
    chk("R5 osc_run", osc_run, 1'b1);
    // R6 held halt code after start
    step(3'b011, 0, 8);
    chk("R6 clk_en", clk_en, 1'b1);

    // R2 unqualified halt codes
    step(3'b101, 0, 2);
    step(3'b011, 0, 8);
    chk("R2 after 101", clk_en, 1'b1);
    step(3'b001, 0, 1);
    step(3'b011, 0, 6);
    chk("R2 after 001", clk_en, 1'b1);

    // R8 stand-alone stop line, external source
    src_ext = 1'b1;
    step(3'b111, 0, 1);
    step(3'b011, 0, 6);
    chk("R8 clk_en", clk_en, 1'b0);
    chk("R4 osc_run external", osc_run, 1'b1);
    step(3'b011, 1, 1);
    step(3'b111, 0, 3);
    chk("R5 restart", clk_en, 1'b1);

    // R5 start inside drain window cancels the stop
    step(3'b111, 0, 2);
    step(3'b011, 0, 1);
    step(3'b011, 1, 1);
    step(3'b011, 0, 6);
    chk("R5 cancel drain", clk_en, 1'b1);
    chk("R5 cancel stopping", stopping, 1'b0);

    // R6 start coinciding with the halt sample
    step(3'b111, 0, 2);
    step(3'b011, 1, 1);
    step(3'b011, 0, 6);
    chk("R6 coincident start", clk_en, 1'b1);

    // Pseudo-random mix, compared by the model each cycle
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      stat    = lf[2] ? 3'b111 : (lf[3] ? 3'b011 : lf[6:4]);
      start   = (lf[11:8] == 4'h0);
      src_ext = lf[12];
    end
    step(3'b111, 0, 4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule